// File: doc/BRIEF.md
# Set/Clear Interrupt Event Controller

This block gathers the interrupt sources of a serial-bus link controller into one level interrupt. It keeps a 32-bit event register and a 32-bit enable mask. Software reaches each register through two write addresses on a small register bus. One address sets the bits written as 1. The other address clears the bits written as 1. Bits written as 0 have no effect at either address, so software never needs a read-modify-write.

Hardware sources latch their event bit on a rising edge. Two summary bits are not stored. Each one is computed live as the OR of a per-context event vector ANDed with its own per-context mask vector. Both vectors come from outside the block. The block also handles two interactions between bits. A bus reset wipes the self-ID-complete event. A latched unrecoverable error stops the hardware completion events from setting. A master enable in the mask gates the single registered interrupt output.

Top module: `irqSetClrTop`

## Requirements
- R1: After reset, the event register, the mask register and `irqOut` are all 0.
- R2: A write to 0x80 sets every event bit where the write data holds a 1. A write to 0x84 clears every event bit where the write data holds a 1. Bits written as 0 keep their value.
- R3: A latched event bit becomes 1 on a rising edge of its hardware source, at the clock edge where the source is first seen high. A source held high does not set the bit again after a clear. Only a clear write removes a latched bit.
- R4: A read at 0x80 or at 0x84 returns the event bits ANDed bit-wise with the mask register.
- R5: A write to 0x88 sets mask bits and a write to 0x8C clears mask bits. A read at 0x88 or at 0x8C returns the plain mask.
- R6: Reserved positions read as 0. For the event register these are bits 31, 29–27, 18 and 15–10. For the mask they are bits 29–27, 18 and 15–10. The writable mask value is therefore 0xC7FB03FF.
- R7: Event bit 7 is the OR over contexts of (rx event AND rx mask). Event bit 6 is the same for tx. Writes to bits 7 and 6 of the event register have no effect.
- R8: `irqOut` is mask bit 31 ANDed with the OR of (event AND mask) over bits 30–0. It is registered, so it follows a change of the registers by one clock. It stays 0 while mask bit 31 is 0.
- R9: When event bit 17 (bus reset) goes from 0 to 1, event bit 16 (self-ID complete) is 0 in the same cycle. This holds whether bit 17 is set by hardware or by a write.
- R10: While event bit 24 (unrecoverable error) is 1, hardware edges on the completion bits 5–0 are ignored. Set writes still take effect.
- R11: The source of event bit 30 is the OR of the two general-purpose inputs, each ANDed with its own enable. Its rising edge sets bit 30. The input `hwEvent[30]` is ignored.
- R12: If a hardware edge and a clear write reach the same bit in the same cycle, the bit ends up set.
- R13: Writes to any other address change nothing. Reads at any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe for one cycle |
| busAddr | input | ADDR_W | Byte address for read and write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, combinational from `busAddr` |
| hwEvent | input | 32 | Hardware event sources, edge-detected on latched bits |
| gpIrq | input | 2 | General-purpose interrupt inputs |
| gpIrqEn | input | 2 | Per-input enables for `gpIrq` |
| isoRxEvt | input | ISO_CTX | Per-context receive events |
| isoRxMask | input | ISO_CTX | Per-context receive masks |
| isoTxEvt | input | ISO_CTX | Per-context transmit events |
| isoTxMask | input | ISO_CTX | Per-context transmit masks |
| irqOut | output | 1 | Registered active-high interrupt |

## Verification
The assertions check four rules on every cycle:
- A latched bit never drops without a clear strobe, except for self-ID complete on a bus reset.
- A hardware edge always leaves its bit set.
- A rising bus reset never coexists with self-ID complete.
- An unrecoverable error stops new completion bits, and a disabled master keeps the interrupt low.

The directed scenarios show what needs exact values:
- the masked read of the event register and the reserved zero positions;
- the live bits following the per-context vectors;
- the edge-only behaviour of a held source and the set-over-clear race;
- the one-cycle latency of the interrupt.

// File: rtl/irqSetClrPkg.sv
package irqSetClrPkg;
  localparam int DATA_W = 32;

  localparam logic [7:0] ADDR_EV_SET = 8'h80;
  localparam logic [7:0] ADDR_EV_CLR = 8'h84;
  localparam logic [7:0] ADDR_MK_SET = 8'h88;
  localparam logic [7:0] ADDR_MK_CLR = 8'h8C;

  localparam int BIT_MASTER = 31;
  localparam int BIT_GPIO   = 30;
  localparam int BIT_FATAL  = 24;
  localparam int BIT_BUSRST = 17;
  localparam int BIT_SELFID = 16;
  localparam int BIT_ISORX  = 7;
  localparam int BIT_ISOTX  = 6;

  // mask bits that exist (reserved positions excluded)
  localparam logic [DATA_W-1:0] MASK_VALID  = 32'hC7FB_03FF;
  // event bits that are stored (no master, no live summary bits)
  localparam logic [DATA_W-1:0] EV_LATCHED  = 32'h47FB_033F;
  // completion bits held off while an unrecoverable error is pending
  localparam logic [DATA_W-1:0] FATAL_BLOCK = 32'h0000_003F;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_EVENT = 2'd1,
    RD_MASK  = 2'd2
  } rdSel_e;

  typedef struct packed {
    logic evSet;
    logic evClr;
    logic mkSet;
    logic mkClr;
  } regStrobe_t;
endpackage

// File: rtl/irqSetClrCtrl.sv
module irqSetClrCtrl
  import irqSetClrPkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobe_t        stb,
  output rdSel_e            rdSel
);
  logic hitEvSet, hitEvClr, hitMkSet, hitMkClr;

  assign hitEvSet = (busAddr == ADDR_W'(ADDR_EV_SET));
  assign hitEvClr = (busAddr == ADDR_W'(ADDR_EV_CLR));
  assign hitMkSet = (busAddr == ADDR_W'(ADDR_MK_SET));
  assign hitMkClr = (busAddr == ADDR_W'(ADDR_MK_CLR));

  always_comb begin
    stb.evSet = busWrEn & hitEvSet;
    stb.evClr = busWrEn & hitEvClr;
    stb.mkSet = busWrEn & hitMkSet;
    stb.mkClr = busWrEn & hitMkClr;
  end

  always_comb begin
    if (hitEvSet || hitEvClr)      rdSel = RD_EVENT;
    else if (hitMkSet || hitMkClr) rdSel = RD_MASK;
    else                           rdSel = RD_NONE;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.evSet, stb.evClr, stb.mkSet, stb.mkClr}) && (busWrEn || (stb == '0))) // R13
    else $error("more than one register strobe");
endmodule

// File: rtl/irqSetClrData.sv
module irqSetClrData
  import irqSetClrPkg::*;
#(
  parameter int ISO_CTX = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         stb,
  input  rdSel_e             rdSel,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic [DATA_W-1:0]  hwEvent,
  input  logic [1:0]         gpIrq,
  input  logic [1:0]         gpIrqEn,
  input  logic [ISO_CTX-1:0] isoRxEvt,
  input  logic [ISO_CTX-1:0] isoRxMask,
  input  logic [ISO_CTX-1:0] isoTxEvt,
  input  logic [ISO_CTX-1:0] isoTxMask,
  output logic               irqOut
);
  logic [DATA_W-1:0] eventReg, maskReg, hwPrev;
  logic [DATA_W-1:0] hwSrc, hwRise, hwRiseEff;
  logic [DATA_W-1:0] evSetVec, evClrVec, evNext, evD, mkD, eventView;
  logic              liveRx, liveTx, busRstRising, irqQ, irqD;

  // hardware sources, bit 30 taken from the general-purpose inputs
  always_comb begin
    hwSrc           = hwEvent & EV_LATCHED;
    hwSrc[BIT_GPIO] = |(gpIrq & gpIrqEn);
  end

  assign hwRise    = hwSrc & ~hwPrev;
  assign hwRiseEff = eventReg[BIT_FATAL] ? (hwRise & ~FATAL_BLOCK) : hwRise;

  assign evSetVec = stb.evSet ? wrData : '0;
  assign evClrVec = stb.evClr ? wrData : '0;

  // per-bit next state: stored bits only, reserved and live bits stay 0
  for (genvar b = 0; b < DATA_W; b++) begin : gEvBit
    if (EV_LATCHED[b]) begin : gStore
      assign evNext[b] = (eventReg[b] & ~evClrVec[b]) | evSetVec[b] | hwRiseEff[b];
    end else begin : gNone
      assign evNext[b] = 1'b0;
    end
  end

  assign busRstRising = evNext[BIT_BUSRST] & ~eventReg[BIT_BUSRST];

  always_comb begin
    evD = evNext;
    if (busRstRising) evD[BIT_SELFID] = 1'b0;
  end

  always_comb begin
    mkD = maskReg;
    if (stb.mkClr) mkD = mkD & ~wrData;
    if (stb.mkSet) mkD = mkD | wrData;
    mkD = mkD & MASK_VALID;
  end

  assign liveRx = |(isoRxEvt & isoRxMask);
  assign liveTx = |(isoTxEvt & isoTxMask);

  always_comb begin
    eventView            = eventReg;
    eventView[BIT_ISORX] = liveRx;
    eventView[BIT_ISOTX] = liveTx;
  end

  assign irqD = maskReg[BIT_MASTER] & (|(eventView[BIT_MASTER-1:0] & maskReg[BIT_MASTER-1:0]));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eventReg <= '0;
      maskReg  <= '0;
      hwPrev   <= '0;
      irqQ     <= 1'b0;
    end else begin
      eventReg <= evD;
      maskReg  <= mkD;
      hwPrev   <= hwSrc;
      irqQ     <= irqD;
    end
  end

  always_comb begin
    unique case (rdSel)
      RD_EVENT: rdData = eventView & maskReg;
      RD_MASK:  rdData = maskReg;
      default:  rdData = '0;
    endcase
  end

  assign irqOut = irqQ;

  AST_NO_SILENT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !stb.evClr |=> ((($past(eventReg) & ~eventReg) & ~(DATA_W'(1) << BIT_SELFID)) == '0)) // R3
    else $error("event bit dropped without clear");

  AST_EDGE_STICKS: assert property (@(posedge clk) disable iff (!rstN)
    ((hwRiseEff & ~(DATA_W'(1) << BIT_SELFID)) != '0)
      |=> ((eventReg & $past(hwRiseEff & ~(DATA_W'(1) << BIT_SELFID)))
           == $past(hwRiseEff & ~(DATA_W'(1) << BIT_SELFID)))) // R12
    else $error("hardware edge lost");

  AST_BUSRST_SELFID: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eventReg[BIT_BUSRST]) |-> !eventReg[BIT_SELFID]) // R9
    else $error("self-ID complete kept across bus reset");

  AST_FATAL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (eventReg[BIT_FATAL] && !stb.evSet)
      |=> ((eventReg[5:0] & ~$past(eventReg[5:0])) == 6'd0)) // R10
    else $error("completion set during unrecoverable error");

  AST_MASTER_GATE: assert property (@(posedge clk) disable iff (!rstN)
    !maskReg[BIT_MASTER] |=> !irqOut) // R8
    else $error("interrupt with master disabled");
endmodule

// File: rtl/irqSetClrTop.sv
module irqSetClrTop
  import irqSetClrPkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int ISO_CTX = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [31:0]        busWrData,
  output logic [31:0]        busRdData,
  input  logic [31:0]        hwEvent,
  input  logic [1:0]         gpIrq,
  input  logic [1:0]         gpIrqEn,
  input  logic [ISO_CTX-1:0] isoRxEvt,
  input  logic [ISO_CTX-1:0] isoRxMask,
  input  logic [ISO_CTX-1:0] isoTxEvt,
  input  logic [ISO_CTX-1:0] isoTxMask,
  output logic               irqOut
);
  regStrobe_t stb;
  rdSel_e     rdSel;

  irqSetClrCtrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .busWrEn (busWrEn),
    .busAddr (busAddr),
    .stb     (stb),
    .rdSel   (rdSel)
  );

  irqSetClrData #(.ISO_CTX(ISO_CTX)) data_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .rdSel     (rdSel),
    .wrData    (busWrData),
    .rdData    (busRdData),
    .hwEvent   (hwEvent),
    .gpIrq     (gpIrq),
    .gpIrqEn   (gpIrqEn),
    .isoRxEvt  (isoRxEvt),
    .isoRxMask (isoRxMask),
    .isoTxEvt  (isoTxEvt),
    .isoTxMask (isoTxMask),
    .irqOut    (irqOut)
  );
endmodule

// File: tb/irqSetClrTop_tb.sv
module irqSetClrTop_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ISO_CTX = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [31:0] hwEvent = '0;
  logic [1:0]  gpIrq = '0, gpIrqEn = '0;
  logic [ISO_CTX-1:0] isoRxEvt = '0, isoRxMask = '0, isoTxEvt = '0, isoTxMask = '0;
  logic        irqOut;
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqSetClrTop #(.ADDR_W(8), .ISO_CTX(ISO_CTX)) dut_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .hwEvent(hwEvent),
    .gpIrq(gpIrq), .gpIrqEn(gpIrqEn), .isoRxEvt(isoRxEvt), .isoRxMask(isoRxMask),
    .isoTxEvt(isoTxEvt), .isoTxMask(isoTxMask), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(posedge clk); @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    busAddr = a; #1; d = busRdData;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wipe();
    hwEvent = '0; gpIrq = '0; gpIrqEn = '0;
    isoRxEvt = '0; isoRxMask = '0; isoTxEvt = '0; isoTxMask = '0;
    tick();
    busWrite(8'h84, 32'hFFFF_FFFF);
    busWrite(8'h8C, 32'hFFFF_FFFF);
  endtask

  task automatic tReset();
    logic [31:0] d;
    busRead(8'h80, d); chk("R1 event after reset", d, 32'h0);
    busRead(8'h88, d); chk("R1 mask after reset", d, 32'h0);
    chk("R1 irq after reset", {31'd0, irqOut}, 32'h0);
  endtask

  task automatic tSetClear();
    logic [31:0] d;
    wipe();
    busWrite(8'h88, 32'hFFFF_FFFF);
    busRead(8'h88, d); chk("R5 R6 mask via set addr", d, 32'hC7FB_03FF);
    busRead(8'h8C, d); chk("R5 mask via clear addr", d, 32'hC7FB_03FF);
    busWrite(8'h80, 32'hFFFF_FFFF);
    busRead(8'h80, d); chk("R2 R6 R9 set all events", d, 32'h47FA_033F);
    busWrite(8'h80, 32'h0);
    busRead(8'h80, d); chk("R2 zero set write no effect", d, 32'h47FA_033F);
    busWrite(8'h84, 32'h0000_000F);
    busRead(8'h84, d); chk("R2 partial clear", d, 32'h47FA_0330);
    busWrite(8'h84, 32'hFFFF_FFFF);
    busRead(8'h80, d); chk("R2 clear all", d, 32'h0);
    busWrite(8'h8C, 32'h0000_0300);
    busRead(8'h88, d); chk("R5 mask clear", d, 32'hC7FB_00FF);
  endtask

  task automatic tMaskedRead();
    logic [31:0] d;
    wipe();
    busWrite(8'h80, 32'h0000_0005);
    busRead(8'h80, d); chk("R4 masked read all off", d, 32'h0);
    busWrite(8'h88, 32'h0000_0001);
    busRead(8'h80, d); chk("R4 masked read set addr", d, 32'h1);
    busRead(8'h84, d); chk("R4 masked read clear addr", d, 32'h1);
    busWrite(8'h88, 32'h0000_0004);
    busRead(8'h80, d); chk("R4 hidden bit revealed", d, 32'h5);
  endtask

  task automatic tEdge();
    logic [31:0] d;
    wipe();
    busWrite(8'h88, 32'hFFFF_FFFF);
    hwEvent[3] = 1'b1; tick();
    busRead(8'h80, d); chk("R3 hw rising edge sets", d, 32'h8);
    busWrite(8'h84, 32'h8);
    tick();
    busRead(8'h80, d); chk("R3 held level no reset", d, 32'h0);
    hwEvent[3] = 1'b0;
    hwEvent[2] = 1'b1;
    busWrite(8'h84, 32'h4);
    busRead(8'h80, d); chk("R12 edge beats clear", d, 32'h4);
    hwEvent[2] = 1'b0;
    hwEvent[30] = 1'b1; hwEvent[12] = 1'b1; tick();
    busRead(8'h80, d); chk("R11 R6 ignored hw bits", d, 32'h4);
  endtask

  task automatic tBusReset();
    logic [31:0] d;
    wipe();
    busWrite(8'h88, 32'hFFFF_FFFF);
    busWrite(8'h80, 32'h0001_0000);
    busRead(8'h80, d); chk("R9 self-ID set", d, 32'h0001_0000);
    hwEvent[17] = 1'b1; tick();
    busRead(8'h80, d); chk("R9 bus reset clears self-ID", d, 32'h0002_0000);
    hwEvent[16] = 1'b1; tick();
    busRead(8'h80, d); chk("R9 self-ID after reset held", d, 32'h0003_0000);
  endtask

  task automatic tFatal();
    logic [31:0] d;
    wipe();
    busWrite(8'h88, 32'hFFFF_FFFF);
    busWrite(8'h80, 32'h0100_0000);
    hwEvent[0] = 1'b1; tick();
    busRead(8'h80, d); chk("R10 completion blocked", d, 32'h0100_0000);
    hwEvent[0] = 1'b0;
    busWrite(8'h80, 32'h0000_0010);
    busRead(8'h80, d); chk("R10 set write still works", d, 32'h0100_0010);
    busWrite(8'h84, 32'h0100_0010);
    hwEvent[1] = 1'b1; tick();
    busRead(8'h80, d); chk("R10 unblocked after clear", d, 32'h2);
  endtask

  task automatic tLive();
    logic [31:0] d;
    wipe();
    busWrite(8'h88, 32'h0000_00C0);
    isoRxEvt = 4'b0010; isoRxMask = 4'b0010;
    busRead(8'h80, d); chk("R7 rx live bit", d, 32'h80);
    isoRxMask = 4'b0100;
    busRead(8'h80, d); chk("R7 rx masked off", d, 32'h0);
    isoTxEvt = 4'b1000; isoTxMask = 4'b1000;
    busRead(8'h80, d); chk("R7 tx live bit", d, 32'h40);
    isoTxEvt = 4'b0;
    busWrite(8'h80, 32'h0000_00C0);
    busRead(8'h80, d); chk("R7 write to live bits ignored", d, 32'h0);
  endtask

  task automatic tGpio();
    logic [31:0] d;
    wipe();
    busWrite(8'h88, 32'h4000_0000);
    gpIrq = 2'b01; tick();
    busRead(8'h80, d); chk("R11 disabled input ignored", d, 32'h0);
    gpIrqEn = 2'b01; tick();
    busRead(8'h80, d); chk("R11 enabled input sets", d, 32'h4000_0000);
  endtask

  task automatic tIrq();
    logic [31:0] d;
    wipe();
    busWrite(8'h88, 32'h0000_0001);
    busWrite(8'h80, 32'h0000_0001);
    tick();
    chk("R8 master off no irq", {31'd0, irqOut}, 32'h0);
    busWrite(8'h88, 32'h8000_0000);
    chk("R8 irq one cycle later", {31'd0, irqOut}, 32'h0);
    tick();
    chk("R8 irq asserted", {31'd0, irqOut}, 32'h1);
    busWrite(8'h84, 32'h1);
    tick();
    chk("R8 irq drops after clear", {31'd0, irqOut}, 32'h0);
    busRead(8'h88, d);
    chk("R8 master bit reads back", d, 32'h8000_0001);
  endtask

  task automatic tUnmapped();
    logic [31:0] d;
    wipe();
    busWrite(8'h90, 32'hFFFF_FFFF);
    busWrite(8'h81, 32'hFFFF_FFFF);
    busRead(8'h88, d); chk("R13 stray write mask", d, 32'h0);
    busWrite(8'h88, 32'hFFFF_FFFF);
    busRead(8'h80, d); chk("R13 stray write event", d, 32'h0);
    busRead(8'h90, d); chk("R13 stray read zero", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tSetClear();
    tMaskedRead();
    tEdge();
    tBusReset();
    tFatal();
    tLive();
    tGpio();
    tIrq();
    tUnmapped();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule